// File: doc/BRIEF.md
# Adjacency-Reduced Walking-One Pattern Generator

This block produces parallel test patterns for checking the wires between chips for shorts. Software first writes an adjacency bit-matrix, one row per net, where a set bit says two nets run next to each other and could be bridged. A start pulse freezes a working copy of that matrix and begins a run. Rather than walking a single 1 across every net, the generator only emits a pattern for a net it selects. In that pattern the selected net drives 1, every net still adjacent to it drives 0, and every other position is left as don't-care so that a later merging stage can combine patterns.

Two modes exist. Diagnosis mode repeatedly picks the net that has the most remaining adjacencies, emits its pattern and then removes all edges that touch that net, until no edge remains. Detection mode emits one pattern for every net that has at least one neighbour, in ascending net order, and removes nothing. Patterns leave on a valid/ready stream that marks the final pattern of a run with a last flag. The controller has three states: IDLE waits for start; SCAN reads one working row per cycle and counts its bits; EMIT holds a pattern on the stream. The transitions are: IDLE to SCAN on start with a non-empty graph, and IDLE stays in IDLE with done raised on start with an empty graph. SCAN moves to EMIT when a net is chosen, and moves to IDLE in detection mode if the last row is reached with no neighbour. EMIT moves to IDLE on the accepted last pattern and otherwise back to SCAN.

Top module: `wo_pattern_gen`

## Requirements
- R1: Entry i of a pattern occupies bits [2i+1:2i] of `pat_data`; code 2'b00 means drive 0, 2'b01 means drive 1, 2'b10 means don't-care, and the reserved code 2'b11 never appears.
- R2: Each pattern has exactly one entry at 2'b01, the selected net; the entries of nets adjacent to it in the current working matrix are 2'b00, and all others are 2'b10.
- R3: In diagnosis mode (`mode` = 0 at start) the selected net is the one with the largest count of remaining edges, and ties go to the lowest net index.
- R4: In diagnosis mode, after a pattern is accepted all edges touching its net are removed, and the run continues while any edge remains.
- R5: In detection mode (`mode` = 1 at start) one pattern is emitted for each net of non-zero degree, in ascending index order, with neighbours taken from the full matrix.
- R6: The working matrix is the loaded matrix OR its transpose, with the diagonal cleared, so self-loops and one-sided entries are handled consistently.
- R7: If the working matrix has no edge, `done` is high in the cycle after start and no pattern is emitted.
- R8: While `pat_valid` is high and `pat_ready` is low, `pat_data` and `pat_last` hold still; `pat_last` is high exactly on the final pattern of a run.
- R9: `done` rises in the cycle after the last pattern is accepted and stays high until the next start. `done` and `pat_valid` are never high together. A start pulse during a run is ignored.
- R10: A row write sets one row of the loaded matrix. Runs do not change the loaded matrix, so a repeated start reproduces the same pattern sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_en | input | 1 | Write one row of the loaded matrix |
| ld_row | input | IDX_W | Row index for the write |
| ld_bits | input | N_NETS | Adjacency bits of that row |
| start | input | 1 | Begin a run (accepted in IDLE only) |
| mode | input | 1 | 0 diagnosis, 1 detection; sampled at start |
| pat_valid | output | 1 | Pattern available |
| pat_ready | input | 1 | Consumer accepts pattern |
| pat_data | output | 2*N_NETS | Pattern, 2-bit code per net |
| pat_last | output | 1 | Final pattern of the run |
| done | output | 1 | Run finished |

## Verification
The bench targets degree ties, which a design that compares with greater-or-equal would resolve toward the highest index, and star and clique graphs, where failing to retire column bits as well as row bits would repeat a net or never finish. It also uses matrices with one-sided entries and self-loops. A design that skipped symmetrising would miss neighbours, and one that kept the diagonal would mark the selected net 0 or never empty the graph. Empty and self-loop-only graphs check that done comes at once with no stray pattern. Random back-pressure with a start pulse in mid-run checks that patterns hold under stall, that last marks only the final pattern, and that a run cannot be restarted.

// File: rtl/wo_pkg.sv
package wo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2
    } gen_state_t;

    typedef enum logic {
        MODE_DIAG   = 1'b0,
        MODE_DETECT = 1'b1
    } gen_mode_t;

    localparam logic [1:0] ENT_ZERO     = 2'b00;
    localparam logic [1:0] ENT_ONE      = 2'b01;
    localparam logic [1:0] ENT_DC       = 2'b10;
    localparam logic [1:0] ENT_CONFLICT = 2'b11;
endpackage

// File: rtl/wo_popcount.sv
module wo_popcount #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_in,
    output logic [CW-1:0] count_out
);
    always_comb begin
        count_out = '0;
        for (int i = 0; i < W; i++) begin
            count_out = count_out + CW'(bits_in[i]);
        end
    end
endmodule

// File: rtl/wo_adj_matrix.sv
module wo_adj_matrix #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_row,
    input  logic [N-1:0]     wr_bits,
    input  logic             snap,
    input  logic             retire_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [N-1:0]     rd_row,
    output logic [N-1:0]     sel_row,
    output logic             sym_empty,
    output logic             rest_empty,
    output logic             tail_empty
);
    logic [N-1:0] loaded [N];
    logic [N-1:0] work   [N];
    logic [N-1:0] sym    [N];
    logic [N-1:0] work_retired [N];

    // R6: symmetric closure without diagonal
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                sym[i][j] = (i != j) && (loaded[i][j] || loaded[j][i]);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                work_retired[i][j] = work[i][j] && (i != int'(sel_idx)) && (j != int'(sel_idx));
            end
        end
    end

    always_comb begin
        sym_empty  = 1'b1;
        rest_empty = 1'b1;
        tail_empty = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (|sym[i])          sym_empty  = 1'b0;
            if (|work_retired[i]) rest_empty = 1'b0;
            if ((i > int'(sel_idx)) && (|work[i])) tail_empty = 1'b0;
        end
    end

    assign rd_row  = work[rd_idx];
    assign sel_row = work[sel_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                loaded[i] <= '0;
                work[i]   <= '0;
            end
        end else begin
            if (wr_en) begin
                loaded[wr_row] <= wr_bits;
            end
            if (snap) begin
                for (int i = 0; i < N; i++) work[i] <= sym[i];
            end else if (retire_en) begin
                for (int i = 0; i < N; i++) work[i] <= work_retired[i];
            end
        end
    end

    // R4
    retire_row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_en && !snap) |=> (work[$past(sel_idx)] == '0));
endmodule

// File: rtl/wo_pattern_fmt.sv
module wo_pattern_fmt
    import wo_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [IDX_W-1:0] sel_idx,
    input  logic [N-1:0]     nbr_row,
    output logic [2*N-1:0]   pat
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        always_comb begin
            if (int'(sel_idx) == g)  pat[2*g +: 2] = ENT_ONE;
            else if (nbr_row[g])     pat[2*g +: 2] = ENT_ZERO;
            else                     pat[2*g +: 2] = ENT_DC;
        end
    end
endmodule

// File: rtl/wo_pattern_gen.sv
module wo_pattern_gen
    import wo_pkg::*;
#(
    parameter  int N_NETS = 8,
    localparam int IDX_W  = $clog2(N_NETS),
    localparam int DEG_W  = $clog2(N_NETS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_en,
    input  logic [IDX_W-1:0]      ld_row,
    input  logic [N_NETS-1:0]     ld_bits,
    input  logic                  start,
    input  logic                  mode,
    output logic                  pat_valid,
    input  logic                  pat_ready,
    output logic [2*N_NETS-1:0]   pat_data,
    output logic                  pat_last,
    output logic                  done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_NETS - 1);

    gen_state_t       state, state_nx;
    gen_mode_t        mode_q;
    logic [IDX_W-1:0] scan_idx, best_idx, sel_idx;
    logic [DEG_W-1:0] best_deg, row_deg;
    logic             done_q;

    logic [N_NETS-1:0] rd_row, sel_row;
    logic              sym_empty, rest_empty, tail_empty;
    logic              snap, retire_en, accept, last_c, take;
    logic [IDX_W-1:0]  final_idx;

    wo_adj_matrix #(.N(N_NETS), .IDX_W(IDX_W)) u_mat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ld_en),
        .wr_row    (ld_row),
        .wr_bits   (ld_bits),
        .snap      (snap),
        .retire_en (retire_en),
        .rd_idx    (scan_idx),
        .sel_idx   (sel_idx),
        .rd_row    (rd_row),
        .sel_row   (sel_row),
        .sym_empty (sym_empty),
        .rest_empty(rest_empty),
        .tail_empty(tail_empty)
    );

    wo_popcount #(.W(N_NETS), .CW(DEG_W)) u_pop (
        .bits_in  (rd_row),
        .count_out(row_deg)
    );

    wo_pattern_fmt #(.N(N_NETS), .IDX_W(IDX_W)) u_fmt (
        .sel_idx(sel_idx),
        .nbr_row(sel_row),
        .pat    (pat_data)
    );

    assign snap      = (state == ST_IDLE) && start;
    assign accept    = (state == ST_EMIT) && pat_ready;
    assign last_c    = (mode_q == MODE_DIAG) ? rest_empty : tail_empty;
    assign retire_en = accept && (mode_q == MODE_DIAG) && !last_c;
    assign take      = row_deg > best_deg;
    assign final_idx = take ? scan_idx : best_idx;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start && !sym_empty) state_nx = ST_SCAN;
            ST_SCAN: begin
                if (mode_q == MODE_DIAG) begin
                    if (scan_idx == LAST_IDX) state_nx = ST_EMIT;
                end else begin
                    if (row_deg != '0)            state_nx = ST_EMIT;
                    else if (scan_idx == LAST_IDX) state_nx = ST_IDLE;
                end
            end
            ST_EMIT: if (pat_ready) state_nx = last_c ? ST_IDLE : ST_SCAN;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_DIAG;
            scan_idx <= '0;
            best_idx <= '0;
            best_deg <= '0;
            sel_idx  <= '0;
            done_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    mode_q   <= gen_mode_t'(mode);
                    scan_idx <= '0;
                    best_idx <= '0;
                    best_deg <= '0;
                    done_q   <= sym_empty;
                end
                ST_SCAN: begin
                    if (mode_q == MODE_DIAG) begin
                        if (take) begin
                            best_deg <= row_deg;
                            best_idx <= scan_idx;
                        end
                        if (scan_idx == LAST_IDX) sel_idx  <= final_idx;
                        else                      scan_idx <= scan_idx + 1'b1;
                    end else begin
                        if (row_deg != '0)             sel_idx  <= scan_idx;
                        else if (scan_idx == LAST_IDX) done_q   <= 1'b1;
                        else                           scan_idx <= scan_idx + 1'b1;
                    end
                end
                ST_EMIT: if (pat_ready) begin
                    if (last_c) begin
                        done_q <= 1'b1;
                    end else if (mode_q == MODE_DIAG) begin
                        scan_idx <= '0;
                        best_idx <= '0;
                        best_deg <= '0;
                    end else begin
                        scan_idx <= sel_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        pat_valid = 1'b0;
        pat_last  = 1'b0;
        unique case (state)
            ST_EMIT: begin
                pat_valid = 1'b1;
                pat_last  = last_c;
            end
            default: ;
        endcase
        done = done_q;
    end

    logic [N_NETS-1:0] ent_one, ent_conf;
    for (genvar g = 0; g < N_NETS; g++) begin : g_chk
        assign ent_one[g]  = (pat_data[2*g +: 2] == ENT_ONE);
        assign ent_conf[g] = (pat_data[2*g +: 2] == ENT_CONFLICT);
    end

    // R1
    no_conflict_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |-> (ent_conf == '0));
    // R2
    single_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |-> ($countones(ent_one) == 1));
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && !pat_ready) |=> (pat_valid && $stable(pat_data) && $stable(pat_last)));
    // R7
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && sym_empty) |=> (done && !pat_valid));
    // R9
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && pat_valid));
endmodule

// File: tb/tb_wo_pattern_gen.sv
module tb_wo_pattern_gen;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ld_en = 1'b0;
    logic [IW-1:0]  ld_row = '0;
    logic [N-1:0]   ld_bits = '0;
    logic           start = 1'b0;
    logic           mode = 1'b0;
    logic           pat_valid;
    logic           pat_ready = 1'b0;
    logic [2*N-1:0] pat_data;
    logic           pat_last;
    logic           done;

    int total = 0;
    int bad   = 0;

    wo_pattern_gen #(.N_NETS(N)) dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row), .ld_bits(ld_bits),
        .start(start), .mode(mode), .pat_valid(pat_valid), .pat_ready(pat_ready),
        .pat_data(pat_data), .pat_last(pat_last), .done(done)
    );

    always #5 clk = ~clk;

    logic [N-1:0]   bm [N];
    logic [2*N-1:0] exp_pat [N];
    int             exp_cnt;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] pat_for(input int s, input logic [N-1:0] nbr);
        logic [2*N-1:0] p;
        for (int j = 0; j < N; j++) begin
            if (j == s)      p[2*j +: 2] = 2'b01;
            else if (nbr[j]) p[2*j +: 2] = 2'b00;
            else             p[2*j +: 2] = 2'b10;
        end
        return p;
    endfunction

    // reference model built from the requirements
    task automatic build_expected(input bit det);
        logic [N-1:0] s [N];
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                s[i][j] = (i != j) && (bm[i][j] || bm[j][i]);
        exp_cnt = 0;
        if (det) begin
            for (int i = 0; i < N; i++)
                if (|s[i]) begin
                    exp_pat[exp_cnt] = pat_for(i, s[i]);
                    exp_cnt++;
                end
        end else begin
            for (int k = 0; k < N; k++) begin
                int bi = 0;
                int bd = 0;
                for (int i = 0; i < N; i++)
                    if ($countones(s[i]) > bd) begin
                        bd = $countones(s[i]);
                        bi = i;
                    end
                if (bd == 0) break;
                exp_pat[exp_cnt] = pat_for(bi, s[bi]);
                exp_cnt++;
                for (int i = 0; i < N; i++) begin
                    s[i][bi] = 1'b0;
                    s[bi][i] = 1'b0;
                end
            end
        end
    endtask

    task automatic load_matrix();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            ld_en = 1'b1;
            ld_row = IW'(i);
            ld_bits = bm[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_case(input bit det, input int ready_pct, input bit inject, input string tag);
        int got = 0;
        int cyc = 0;
        bit pend = 1'b0;
        logic [2*N-1:0] prev = '0;
        logic prev_last = 1'b0;
        string req;
        req = det ? "R5" : "R3/R4";
        build_expected(det);
        @(negedge clk);
        start = 1'b1;
        mode = det;
        @(negedge clk);
        start = 1'b0;
        if (exp_cnt == 0) begin
            // R7: done one cycle after start, nothing on the stream
            chk(done == 1'b1 && pat_valid == 1'b0, {"R7 empty ", tag}, {pat_valid, done}, 2'b01);
            return;
        end
        chk(done == 1'b0, {"R9 done cleared by start ", tag}, done, 0);
        while (got < exp_cnt && cyc < 3000) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            if (inject && cyc == 4) begin start = 1'b1; mode = ~det; end
            else start = 1'b0;
            if (pend) begin
                chk(pat_valid && pat_data == prev && pat_last == prev_last,
                    {"R8 stall hold ", tag}, pat_data, prev);
            end
            pat_ready = (($urandom % 100) < ready_pct);
            if (pat_valid && pat_ready) begin
                chk(pat_data == exp_pat[got], {req, " R2 R1 R6 pattern ", tag}, pat_data, exp_pat[got]);
                chk(pat_last == (got == exp_cnt - 1), {"R8 last flag ", tag}, pat_last, (got == exp_cnt - 1));
                got++;
                pend = 1'b0;
            end else begin
                pend = pat_valid;
                prev = pat_data;
                prev_last = pat_last;
            end
        end
        start = 1'b0;
        chk(got == exp_cnt, {req, " pattern count ", tag}, got, exp_cnt);
        @(negedge clk);
        pat_ready = 1'b0;
        chk(done == 1'b1 && pat_valid == 1'b0, {"R9 done after last ", tag}, {pat_valid, done}, 2'b01);
        repeat (3) @(negedge clk);
        chk(done == 1'b1 && pat_valid == 1'b0, {"R9 done held, no extra ", tag}, {pat_valid, done}, 2'b01);
    endtask

    task automatic clear_bm();
        for (int i = 0; i < N; i++) bm[i] = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(pat_valid == 1'b0 && done == 1'b0, "R9 reset state", {pat_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pat_valid == 1'b0 && done == 1'b0, "R9 idle after reset", {pat_valid, done}, 0);

        // R7 empty graph, both modes
        clear_bm(); load_matrix();
        run_case(1'b0, 100, 1'b0, "empty diag");
        run_case(1'b1, 100, 1'b0, "empty det");

        // R6 self-loops only behave as empty
        for (int i = 0; i < N; i++) bm[i][i] = 1'b1;
        load_matrix();
        run_case(1'b0, 100, 1'b0, "selfloops R6");

        // R6 one-sided star centred on net 5
        clear_bm();
        for (int i = 0; i < N; i++) if (i != 5) bm[i][5] = 1'b1;
        load_matrix();
        run_case(1'b0, 70, 1'b0, "star R6");
        run_case(1'b1, 70, 1'b0, "star det");

        // R3 path 0-1-2-3-4: ties among 1,2,3 go low
        clear_bm();
        for (int i = 0; i < 4; i++) bm[i][i+1] = 1'b1;
        load_matrix();
        run_case(1'b0, 50, 1'b0, "path tie");

        // R4 full clique
        for (int i = 0; i < N; i++) bm[i] = '1;
        load_matrix();
        run_case(1'b0, 60, 1'b0, "clique");
        run_case(1'b1, 60, 1'b0, "clique det");

        // R10 repeat without reload, R9 start injected mid-run
        run_case(1'b0, 40, 1'b1, "clique repeat R10");

        // random graphs of varying density
        for (int t = 0; t < 30; t++) begin
            int dens = 10 + (t % 6) * 15;
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    bm[i][j] = (($urandom % 100) < dens);
            load_matrix();
            run_case(t[0], 30 + (t % 3) * 30, (t % 5) == 0, $sformatf("rand%0d", t));
            run_case(t[0], 100, 1'b0, $sformatf("rand%0d rerun R10", t));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule